// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a clock-sampled model of a 16-bit static memory that sits behind a bidirectional data pad. The pad is split into three signals: `dq_in`, `dq_out` and a per-lane drive enable `dq_oe`. The pad ring can therefore place the tristate buffers outside the block. Two chip enables of opposite polarity, a write enable, an output enable and two byte-lane enables decide whether a cycle reads, writes or leaves the lanes undriven.

A mode input selects the organization.

- **Word mode:** each location holds 16 bits, and the two lanes are read and written independently.
- **Byte mode:** data line 15 stops carrying data and becomes the least significant address bit. That bit picks the low or high half of the addressed word, which doubles the number of locations. All byte traffic moves on lines 0 to 7.

Writes take effect on the rising clock edge while the write condition holds. Reads are combinational from the array. The array depth comes from the word-address width parameter.

Top module: `bytelane_sram`

## Requirements
- R1: The block is selected only when `cs_lo_n` is 0 and `cs_hi` is 1. When it is not selected, `dq_oe` is 2'b00 and no clock edge changes the array.
- R2: In word mode with both `lane_lo_n` and `lane_hi_n` at 1, `dq_oe` is 2'b00 and no write occurs, even when the block is selected.
- R3: A word-mode read (`we_n`=1, `oe_n`=0) works lane by lane:
  - `lane_lo_n`=0 sets `dq_oe[0]` and puts stored bits 7:0 on `dq_out[7:0]`.
  - `lane_hi_n`=0 sets `dq_oe[1]` and puts stored bits 15:8 on `dq_out[15:8]`.
  - A lane that is not read shows 8'h00 on its `dq_out` bits.
- R4: A word-mode write (`we_n`=0) updates, at the rising clock edge, only the lanes whose enable is 0; the other lane keeps its value. `oe_n` has no effect during a write, and `dq_oe` is 2'b00 while `we_n` is 0.
- R5: When the block is selected with `we_n`=1 and `oe_n`=1, `dq_oe` is 2'b00.
- R6: Byte mode is `word_mode`=0. The location is `{addr, dq_in[15]}`: `dq_in[15]`=0 selects bits 7:0 of word `addr`, and 1 selects bits 15:8. Byte data moves on lines 7:0. `lane_lo_n`, `lane_hi_n` and `dq_in[14:8]` are ignored.
- R7: A byte-mode write updates only the selected half of the addressed word. The other half keeps its value.
- R8: A byte-mode read drives `dq_oe`=2'b01 with the selected byte on `dq_out[7:0]`, and `dq_out[15:8]` is 8'h00.
- R9: While `rst_n` is 0, and for the first two rising edges after it returns to 1, the block acts as deselected: no lane is driven and no write occurs. Array contents are not cleared by reset.
- R10: Data written at a rising edge is returned by a read in the same cycle that follows that edge, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | WORD_AW | Word address |
| cs_lo_n | input | 1 | Active-low chip enable |
| cs_hi | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lane_lo_n | input | 1 | Active-low enable for lines 7:0 (word mode) |
| lane_hi_n | input | 1 | Active-low enable for lines 15:8 (word mode) |
| word_mode | input | 1 | 1 = 16-bit words, 0 = bytes with line 15 as low address bit |
| dq_in | input | 16 | Data from the pad (line 15 is an address bit in byte mode) |
| dq_out | output | 16 | Data to the pad |
| dq_oe | output | 2 | Pad drive enable per lane: bit 0 for 7:0, bit 1 for 15:8 |

## Verification
The checker assumes that control inputs change only away from the rising edge and are stable across it. It also assumes that the address does not move during a write cycle; the write-then-read property relies on this. The bench drives every input on the falling edge and holds it through the following rising edge. It holds `dq_in[15]` at the intended half-select for the whole byte-mode cycle, and it never mixes a mode change with a write in the same cycle. Reads target only locations written earlier, so no check depends on the contents of an unwritten array.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int DATA_W  = LANE_W * LANES;

  typedef struct packed {
    logic [LANES-1:0] rd;        // stored lanes being read
    logic [LANES-1:0] wr;        // stored lanes being written
    logic             half;      // byte mode: 1 = upper stored lane
    logic             byte_mode; // 1 = 8-bit organization
  } bls_ctl_t;
endpackage

// File: rtl/bls_rst_sync.sv
module bls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic              rst_ok,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] dq_in,
  output bls_ctl_t          ctl,
  output logic [DATA_W-1:0] wdata
);
  logic             sel, rd_cyc, wr_cyc;
  logic [LANES-1:0] lane_on;

  always_comb begin
    sel    = rst_ok & ~cs_lo_n & cs_hi;
    rd_cyc = sel & we_n & ~oe_n;
    wr_cyc = sel & ~we_n;

    if (word_mode) begin
      lane_on = {~lane_hi_n, ~lane_lo_n};
      wdata   = dq_in;
    end else begin
      lane_on = dq_in[DATA_W-1] ? 2'b10 : 2'b01;
      wdata   = {LANES{dq_in[LANE_W-1:0]}};
    end

    ctl.rd        = rd_cyc ? lane_on : '0;
    ctl.wr        = wr_cyc ? lane_on : '0;
    ctl.half      = dq_in[DATA_W-1];
    ctl.byte_mode = ~word_mode;
  end
endmodule

// File: rtl/bls_array.sv
module bls_array
  import bls_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic               clk,
  input  logic [LANES-1:0]   wr_en,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] addr,
  input  logic               cs_lo_n,
  input  logic               cs_hi,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               lane_lo_n,
  input  logic               lane_hi_n,
  input  logic               word_mode,
  input  logic [15:0]        dq_in,
  output logic [15:0]        dq_out,
  output logic [1:0]         dq_oe
);
  logic              rst_ok;
  bls_ctl_t          ctl;
  logic [DATA_W-1:0] wdata, rdata;

  bls_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  bls_decode u_dec (
    .rst_ok(rst_ok), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .we_n(we_n),
    .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .word_mode(word_mode), .dq_in(dq_in), .ctl(ctl), .wdata(wdata)
  );

  bls_array #(.WORD_AW(WORD_AW)) u_arr (
    .clk(clk), .wr_en(ctl.wr), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Output steering: byte mode folds the chosen stored lane onto lines 7:0.
  always_comb begin
    dq_out = '0;
    dq_oe  = '0;
    if (ctl.byte_mode) begin
      if (|ctl.rd) begin
        dq_out[LANE_W-1:0] = ctl.half ? rdata[DATA_W-1:LANE_W] : rdata[LANE_W-1:0];
        dq_oe              = 2'b01;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (ctl.rd[l]) dq_out[l*LANE_W +: LANE_W] = rdata[l*LANE_W +: LANE_W];
      end
      dq_oe = ctl.rd;
    end
  end
endmodule

// File: rtl/bls_sram_chk.sv
module bls_sram_chk #(
  parameter int WORD_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_ok,
  input logic [WORD_AW-1:0] addr,
  input logic               cs_lo_n,
  input logic               cs_hi,
  input logic               we_n,
  input logic               oe_n,
  input logic               lane_lo_n,
  input logic               lane_hi_n,
  input logic               word_mode,
  input logic [15:0]        dq_in,
  input logic [15:0]        dq_out,
  input logic [1:0]         dq_oe
);
  logic wr_lo_word;
  assign wr_lo_word = rst_ok && !cs_lo_n && cs_hi && !we_n && word_mode && !lane_lo_n;

  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_lo_n && cs_hi) |-> dq_oe == 2'b00);

  p_lanes_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && lane_lo_n && lane_hi_n) |-> dq_oe == 2'b00);

  p_write_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe == 2'b00);

  p_oe_high_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> dq_oe == 2'b00);

  p_byte_upper_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (!dq_oe[1] && dq_out[15:8] == 8'h00));

  p_write_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_lo_word) && word_mode && dq_oe[0] && addr == $past(addr))
      |-> dq_out[7:0] == $past(dq_in[7:0]));

  p_rst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> dq_oe == 2'b00);
endmodule

bind bytelane_sram bls_sram_chk #(.WORD_AW(WORD_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .addr(addr),
  .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .we_n(we_n), .oe_n(oe_n),
  .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .word_mode(word_mode),
  .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_bytelane_sram.sv
`timescale 1ns/1ps
module tb_bytelane_sram;
  localparam int WORD_AW = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [WORD_AW-1:0] addr;
  logic               cs_lo_n, cs_hi, we_n, oe_n, lane_lo_n, lane_hi_n, word_mode;
  logic [15:0]        dq_in, dq_out;
  logic [1:0]         dq_oe;
  int                 checks = 0;
  int                 failures = 0;

  always #2 clk = ~clk;

  bytelane_sram #(.WORD_AW(WORD_AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .we_n(we_n), .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .word_mode(word_mode), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic        wr;
    logic        wm;
    logic        lo_n;
    logic        hi_n;
    logic [9:0]  a;
    logic [15:0] din;
    logic [1:0]  eoe;
    logic [15:0] eout;
  } vec_t;

  localparam vec_t VT [13] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'hA1B2, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 16'h0000, 2'b11, 16'hA1B2},
    '{1'b1, 1'b1, 1'b0, 1'b1, 10'd5, 16'h3344, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 16'h0000, 2'b11, 16'hA144},
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd5, 16'h5566, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 16'h0000, 2'b01, 16'h0044},
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 16'h0000, 2'b10, 16'h5500},
    '{1'b1, 1'b0, 1'b1, 1'b1, 10'd7, 16'h7F12, 2'b00, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 16'h8034, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 16'h0000, 2'b11, 16'h3412},
    '{1'b0, 1'b0, 1'b1, 1'b1, 10'd7, 16'h0000, 2'b01, 16'h0012},
    '{1'b0, 1'b0, 1'b0, 1'b0, 10'd7, 16'h8000, 2'b01, 16'h0034},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd5, 16'h8000, 2'b01, 16'h0055}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_lo_n = 1'b0; cs_hi = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lane_lo_n = 1'b1; lane_hi_n = 1'b1; word_mode = 1'b1; dq_in = '0;
  endtask

  // Inputs set on the falling edge, sampled by the write at the next rising edge.
  task automatic apply(input logic wr, input logic wm, input logic lo_n, input logic hi_n,
                       input logic [9:0] a, input logic [15:0] din, input logic oen);
    @(negedge clk);
    word_mode = wm; lane_lo_n = lo_n; lane_hi_n = hi_n; addr = a; dq_in = din;
    we_n = ~wr; oe_n = oen;
    #1;
  endtask

  task automatic finish_write();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic read_word(input logic [9:0] a, input string tag, input logic [15:0] exp);
    apply(1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0000, 1'b0);
    chk(tag, dq_out, exp);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr = '0;
    idle();
    oe_n = 1'b0; lane_lo_n = 1'b0; lane_hi_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset read undriven", {14'd0, dq_oe}, 16'h0000);
    rst_n = 1'b1;
    idle();
    repeat (3) @(posedge clk);

    // Table walk: R3 R4 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      apply(VT[i].wr, VT[i].wm, VT[i].lo_n, VT[i].hi_n, VT[i].a, VT[i].din, 1'b0);
      chk($sformatf("table R3 R4 R6 R7 R8 vec %0d oe", i), {14'd0, dq_oe}, {14'd0, VT[i].eoe});
      if (VT[i].wr) finish_write();
      else chk($sformatf("table R3 R6 R8 vec %0d data", i), dq_out, VT[i].eout);
    end

    // R1: deselected by either enable, no drive and no write
    apply(1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 16'h0000, 1'b0);
    cs_lo_n = 1'b1; #1;
    chk("R1 cs_lo_n high undriven", {14'd0, dq_oe}, 16'h0000);
    we_n = 1'b0; dq_in = 16'hFFFF;
    finish_write();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'hEEEE, 1'b0);
    cs_hi = 1'b0; #1;
    chk("R1 cs_hi low undriven", {14'd0, dq_oe}, 16'h0000);
    finish_write();
    read_word(10'd5, "R1 no write when deselected", 16'h5544);

    // R2: both lane enables high
    apply(1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 16'h0000, 1'b0);
    chk("R2 lanes off read undriven", {14'd0, dq_oe}, 16'h0000);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 10'd5, 16'hDDDD, 1'b0);
    finish_write();
    read_word(10'd5, "R2 no write with lanes off", 16'h5544);

    // R5: output enable high
    apply(1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 16'h0000, 1'b1);
    chk("R5 oe_n high undriven", {14'd0, dq_oe}, 16'h0000);

    // R4: oe_n low ignored during write; R10 readback right after the edge
    apply(1'b1, 1'b1, 1'b0, 1'b1, 10'd9, 16'h00C3, 1'b0);
    chk("R4 write with oe_n low undriven", {14'd0, dq_oe}, 16'h0000);
    finish_write();
    apply(1'b0, 1'b1, 1'b0, 1'b1, 10'd9, 16'h0000, 1'b0);
    chk("R10 readback after write edge", dq_out, 16'h00C3);

    // R9: write during reset is blocked, contents survive reset
    @(negedge clk);
    rst_n = 1'b0;
    apply(1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'h9999, 1'b0);
    finish_write();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'h8888, 1'b0);
    rst_n = 1'b1;
    finish_write();
    repeat (3) @(posedge clk);
    read_word(10'd5, "R9 no write around reset, data kept", 16'h5544);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule